// File: doc/BRIEF.md
# Bus Command Decoder and Channel Sequencer

This block is the serial front end of a small multi-channel data acquisition device. It samples a two-wire bus (clock and data) with the system clock, finds START and STOP conditions, and shifts in the first byte after each START. That first byte is the whole command. Its upper nibble names the device, and the lower nibble picks conversion or limit-register access, the channel, and whether a read follows. When the identifier matches, the block pulls the data line low for the acknowledge clock. It then presents the decoded mode to the converter and the limit store that sit next to it.

For conversion commands the block also controls the sample-and-hold. The track output is high through the acknowledge period. On the first rising bus clock after the acknowledge the block switches to hold and emits a single-cycle conversion-start pulse. A channel code of 11 on a conversion command turns on auto-increment: the channel index starts at 0 and moves to the next channel on every conversion-done pulse, wrapping after the last channel. A parameter sets the number of channels (two or three). A second parameter chooses between a fixed identifier and one formed from three strap pins.

Top module: `daq_cmd_front`

## Requirements
- R1: A START is a falling data line while the bus clock is high, and a STOP is a rising data line while the bus clock is high. Bytes clocked while no START has been seen since reset are ignored.
- R2: The byte is taken MSB first on the rising bus-clock edges. Bits 7..4 are compared with the identifier: 1001 in the fixed variant, or {strap_pins[2:0], 1} in the strapped variant. On a match, `sda_oe` is high from the falling edge after bit 0 until the falling edge that ends the ninth clock.
- R3: On an identifier mismatch, `sda_oe` stays low and all mode outputs stay cleared until the next START.
- R4: Bit 3 = 0 means conversion, so `is_conv` = 1. Bit 3 = 1 means limit-register access, so `is_conv` = 0, and `track` and `conv_start` stay low.
- R5: For channel codes 00, 01 and 10 in bits 2..1, `chan_idx` equals the code.
- R6: Channel code 11 with bit 3 = 0 sets `auto_inc` and loads `chan_idx` = 0. Code 11 with bit 3 = 1 leaves `auto_inc` low.
- R7: While `auto_inc` is high, each `conv_done` pulse advances `chan_idx` by one. After channel NUM_CH-1 it wraps to 0.
- R8: `is_read` equals bit 0 of an accepted command.
- R9: On a conversion command, `track` is high from the start of the acknowledge period until the next rising bus-clock edge. `conv_start` pulses for exactly one cycle at that edge, and `track` is low in the following cycle.
- R10: The mode outputs (`cmd_valid`, `is_conv`, `is_read`, `auto_inc`) stay in place across a STOP and are cleared only by the next START. Auto-increment stepping continues after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line (as seen on the wire) |
| strap_pins | input | 3 | Identifier strap pins (strapped variant) |
| conv_done | input | 1 | Converter finished a conversion |
| sda_oe | output | 1 | Pull data line low (acknowledge) |
| track | output | 1 | Sample-and-hold in track mode |
| conv_start | output | 1 | One-cycle conversion start |
| chan_idx | output | 2 | Selected analog channel |
| cmd_valid | output | 1 | An accepted command is in force |
| is_conv | output | 1 | Command targets the converter |
| is_read | output | 1 | Command reads data back |
| auto_inc | output | 1 | Auto-increment channel stepping active |

## Verification
The hardest situation to reach from the ports is the wrap of an auto-increment sequence once the bus has gone quiet. The stimulus has to complete a matching auto-increment command, issue STOP, and then deliver enough `conv_done` pulses to pass the last channel. Meanwhile a second instance, built as the two-channel strapped variant, shares the same wires. One command then hits one identifier and misses the other, so both the ignore path and the shorter wrap are seen on the same traffic. A behavioural model of the first instance is compared on every clock. It pins the exact cycle of the acknowledge, the track-to-hold edge and the conversion-start pulse relative to the two-flop synchronizer delay.

// File: rtl/daq_cmd_pkg.sv
package daq_cmd_pkg;

    localparam int          CMD_BITS = 8;
    localparam int          CNT_W    = 4;
    localparam logic [1:0]  CH_AUTO  = 2'b11;
    localparam logic [3:0]  FIXED_ID = 4'b1001;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic [3:0] ident;
        logic       to_limit;
        logic [1:0] chan;
        logic       rd;
    } cmd_byte_t;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_SHIFT,
        ENG_ACK,
        ENG_TRACK,
        ENG_ACTIVE,
        ENG_IGNORE
    } eng_state_t;

    function automatic logic [3:0] expected_id(input logic strapped, input logic [2:0] pins);
        return strapped ? {pins, 1'b1} : FIXED_ID;
    endfunction

    function automatic logic wants_auto(input logic to_limit, input logic [1:0] chan);
        return !to_limit && (chan == CH_AUTO);
    endfunction

    function automatic logic [1:0] step_chan(input logic [1:0] cur, input logic [1:0] last);
        return (cur == last) ? 2'd0 : cur + 2'd1;
    endfunction

endpackage

// File: rtl/daq_bus_sampler.sv
module daq_bus_sampler
    import daq_cmd_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] scl_p, sda_p;
    logic              scl_d, sda_d;
    logic              scl_s, sda_s;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_p <= '1;
                    sda_p <= '1;
                end else begin
                    scl_p <= scl_in;
                    sda_p <= sda_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_p <= '1;
                    sda_p <= '1;
                end else begin
                    scl_p <= {scl_p[STAGES-2:0], scl_in};
                    sda_p <= {sda_p[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    assign scl_s = scl_p[TOP];
    assign sda_s = sda_p[TOP];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        ev.start = scl_s && scl_d && sda_d && !sda_s;
        ev.stop  = scl_s && scl_d && !sda_d && sda_s;
        ev.rise  = scl_s && !scl_d;
        ev.fall  = !scl_s && scl_d;
        ev.sda   = sda_s;
    end

    AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ev.start && ev.stop)); // R1
    AST_COND_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
        (ev.start || ev.stop) |-> !ev.rise && !ev.fall); // R1

endmodule

// File: rtl/daq_cmd_engine.sv
module daq_cmd_engine
    import daq_cmd_pkg::*;
#(
    parameter bit STRAPPED = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic [2:0] strap_pins,
    output logic       load,
    output logic       to_limit,
    output logic [1:0] chan_code,
    output logic       rd_bit,
    output logic       sda_oe,
    output logic       track,
    output logic       conv_start
);
    eng_state_t       st;
    logic [CNT_W-1:0] bitcnt;
    cmd_byte_t        shreg;
    logic [3:0]       dev_id;
    logic             byte_end;
    logic             id_ok;

    assign dev_id   = expected_id(STRAPPED, strap_pins);
    assign byte_end = (st == ENG_SHIFT) && ev.fall && (bitcnt == CNT_W'(CMD_BITS));
    assign id_ok    = (shreg.ident == dev_id);
    assign load     = byte_end && id_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ENG_IDLE;
            bitcnt <= '0;
            shreg  <= '0;
        end else if (ev.start) begin
            st     <= ENG_SHIFT;
            bitcnt <= '0;
            shreg  <= '0;
        end else if (ev.stop) begin
            st     <= ENG_IDLE;
        end else begin
            unique case (st)
                ENG_SHIFT: begin
                    if (ev.rise && bitcnt < CNT_W'(CMD_BITS)) begin
                        shreg  <= {shreg[CMD_BITS-2:0], ev.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_end) begin
                        st <= id_ok ? ENG_ACK : ENG_IGNORE;
                    end
                end
                ENG_ACK: begin
                    if (ev.fall) st <= shreg.to_limit ? ENG_ACTIVE : ENG_TRACK;
                end
                ENG_TRACK: begin
                    if (ev.rise) st <= ENG_ACTIVE;
                end
                default: st <= st;
            endcase
        end
    end

    assign to_limit   = shreg.to_limit;
    assign chan_code  = shreg.chan;
    assign rd_bit     = shreg.rd;
    assign sda_oe     = (st == ENG_ACK);
    assign track      = ((st == ENG_ACK) && !shreg.to_limit) || (st == ENG_TRACK);
    assign conv_start = (st == ENG_TRACK) && ev.rise;

    AST_ACK_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> (shreg.ident == dev_id)); // R2
    AST_START_RELEASES: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> !sda_oe && !track); // R1
    AST_HOLD_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !track && !conv_start); // R9
    AST_NO_TRACK_LIMIT: assert property (@(posedge clk) disable iff (rst)
        track |-> !shreg.to_limit); // R4

endmodule

// File: rtl/daq_chan_stepper.sv
module daq_chan_stepper
    import daq_cmd_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       load,
    input  logic       to_limit,
    input  logic [1:0] chan_code,
    input  logic       rd_bit,
    input  logic       conv_done,
    output logic [1:0] chan_idx,
    output logic       cmd_valid,
    output logic       is_conv,
    output logic       is_read,
    output logic       auto_inc
);
    localparam logic [1:0] LAST = 2'(NUM_CH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_idx  <= '0;
            cmd_valid <= 1'b0;
            is_conv   <= 1'b0;
            is_read   <= 1'b0;
            auto_inc  <= 1'b0;
        end else if (clr) begin
            cmd_valid <= 1'b0;
            is_conv   <= 1'b0;
            is_read   <= 1'b0;
            auto_inc  <= 1'b0;
        end else if (load) begin
            cmd_valid <= 1'b1;
            is_conv   <= !to_limit;
            is_read   <= rd_bit;
            auto_inc  <= wants_auto(to_limit, chan_code);
            chan_idx  <= wants_auto(to_limit, chan_code) ? 2'd0 : chan_code;
        end else if (conv_done && auto_inc) begin
            chan_idx  <= step_chan(chan_idx, LAST);
        end
    end

    AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        auto_inc |-> chan_idx <= LAST); // R7
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (auto_inc && conv_done && !clr && !load && chan_idx == LAST) |=> chan_idx == 2'd0); // R7
    AST_AUTO_NEEDS_CONV: assert property (@(posedge clk) disable iff (rst)
        auto_inc |-> is_conv && cmd_valid); // R6

endmodule

// File: rtl/daq_cmd_front.sv
module daq_cmd_front
    import daq_cmd_pkg::*;
#(
    parameter int NUM_CH      = 3,
    parameter bit STRAPPED    = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] strap_pins,
    input  logic       conv_done,
    output logic       sda_oe,
    output logic       track,
    output logic       conv_start,
    output logic [1:0] chan_idx,
    output logic       cmd_valid,
    output logic       is_conv,
    output logic       is_read,
    output logic       auto_inc
);
    bus_ev_t    ev;
    logic       load, to_limit, rd_bit;
    logic [1:0] chan_code;

    daq_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    daq_cmd_engine #(.STRAPPED(STRAPPED)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .strap_pins (strap_pins),
        .load       (load),
        .to_limit   (to_limit),
        .chan_code  (chan_code),
        .rd_bit     (rd_bit),
        .sda_oe     (sda_oe),
        .track      (track),
        .conv_start (conv_start)
    );

    daq_chan_stepper #(.NUM_CH(NUM_CH)) u_stepper (
        .clk       (clk),
        .rst       (rst),
        .clr       (ev.start),
        .load      (load),
        .to_limit  (to_limit),
        .chan_code (chan_code),
        .rd_bit    (rd_bit),
        .conv_done (conv_done),
        .chan_idx  (chan_idx),
        .cmd_valid (cmd_valid),
        .is_conv   (is_conv),
        .is_read   (is_read),
        .auto_inc  (auto_inc)
    );

    AST_TRACK_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
        track |-> cmd_valid && is_conv); // R4
    AST_START_CLEARS_MODE: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> !cmd_valid && !auto_inc); // R10

endmodule

// File: tb/daq_cmd_front_tb.sv
`timescale 1ns/1ps
module daq_cmd_front_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_drv = 1'b1;
    logic conv_done = 1'b0;
    logic sda_line;

    logic       a_oe, a_trk, a_cs, a_val, a_conv, a_rd, a_auto;
    logic [1:0] a_ch;
    logic       b_oe, b_trk, b_cs, b_val, b_conv, b_rd, b_auto;
    logic [1:0] b_ch;

    int total = 0;
    int bad = 0;
    int cs_cnt = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_drv & ~a_oe & ~b_oe;

    daq_cmd_front #(.NUM_CH(3), .STRAPPED(1'b0)) dut_i (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
        .strap_pins(3'b000), .conv_done(conv_done),
        .sda_oe(a_oe), .track(a_trk), .conv_start(a_cs), .chan_idx(a_ch),
        .cmd_valid(a_val), .is_conv(a_conv), .is_read(a_rd), .auto_inc(a_auto)
    );

    daq_cmd_front #(.NUM_CH(2), .STRAPPED(1'b1)) dut_b_i (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
        .strap_pins(3'b010), .conv_done(conv_done),
        .sda_oe(b_oe), .track(b_trk), .conv_start(b_cs), .chan_idx(b_ch),
        .cmd_valid(b_val), .is_conv(b_conv), .is_read(b_rd), .auto_inc(b_auto)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model of dut_i (three channels, fixed identifier 1001)
    int m_c1, m_c2, m_cd, m_d1, m_d2, m_dd;
    int m_phase, m_nbits, m_byte;
    int m_val, m_conv, m_rd, m_auto, m_ch;

    always @(posedge clk) begin
        if (rst) begin
            m_c1 = 1; m_c2 = 1; m_cd = 1; m_d1 = 1; m_d2 = 1; m_dd = 1;
            m_phase = 0; m_nbits = 0; m_byte = 0;
            m_val = 0; m_conv = 0; m_rd = 0; m_auto = 0; m_ch = 0;
        end else begin
            int up, dn, st_c, sp_c, took;
            up   = (m_c2 == 1 && m_cd == 0);
            dn   = (m_c2 == 0 && m_cd == 1);
            st_c = (m_c2 == 1 && m_cd == 1 && m_dd == 1 && m_d2 == 0);
            sp_c = (m_c2 == 1 && m_cd == 1 && m_dd == 0 && m_d2 == 1);
            took = 0;
            if (st_c) begin
                m_phase = 1; m_nbits = 0; m_byte = 0;
                m_val = 0; m_conv = 0; m_rd = 0; m_auto = 0;
            end else if (sp_c) begin
                m_phase = 0;
            end else if (m_phase == 1) begin
                if (up && m_nbits < 8) begin
                    m_byte = ((m_byte << 1) | m_d2) & 255;
                    m_nbits++;
                end else if (dn && m_nbits == 8) begin
                    if ((m_byte >> 4) == 9) begin
                        m_phase = 2; took = 1;
                        m_val  = 1;
                        m_conv = ((m_byte >> 3) & 1) == 0;
                        m_rd   = m_byte & 1;
                        m_auto = m_conv && (((m_byte >> 1) & 3) == 3);
                        m_ch   = m_auto ? 0 : ((m_byte >> 1) & 3);
                    end else begin
                        m_phase = 5;
                    end
                end
            end else if (m_phase == 2) begin
                if (dn) m_phase = m_conv ? 3 : 4;
            end else if (m_phase == 3) begin
                if (up) m_phase = 4;
            end
            if (!st_c && !took && conv_done && m_auto)
                m_ch = (m_ch == 2) ? 0 : m_ch + 1;
            m_cd = m_c2; m_c2 = m_c1; m_c1 = scl;
            m_dd = m_d2; m_d2 = m_d1; m_d1 = sda_line;
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R2 sda_oe",     a_oe,   m_phase == 2);
            chk("R9 track",      a_trk,  (m_phase == 2 && m_conv) || m_phase == 3);
            chk("R9 conv_start", a_cs,   m_phase == 3 && m_c2 == 1 && m_cd == 0);
            chk("R5 chan_idx",   a_ch,   m_ch);
            chk("R10 cmd_valid", a_val,  m_val);
            chk("R4 is_conv",    a_conv, m_conv);
            chk("R8 is_read",    a_rd,   m_rd);
            chk("R6 auto_inc",   a_auto, m_auto);
            if (a_cs) cs_cnt++;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; scl = 1'b1; wait_clk(6);
        sda_drv = 1'b0; wait_clk(8);
        scl = 1'b0; wait_clk(4);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wait_clk(4);
        scl = 1'b1; wait_clk(8);
        sda_drv = 1'b1; wait_clk(8);
    endtask

    task automatic bus_bit(input logic b);
        sda_drv = b; wait_clk(4);
        scl = 1'b1; wait_clk(8);
        scl = 1'b0; wait_clk(4);
    endtask

    // Sends the command byte and the acknowledge clock; reports what both units did mid-ACK
    task automatic send_cmd(input logic [7:0] b, output logic ack_a, output logic ack_b,
                            output logic trk_a);
        for (int i = 7; i >= 0; i--) bus_bit(b[i]);
        sda_drv = 1'b1; wait_clk(4);
        scl = 1'b1; wait_clk(4);
        ack_a = a_oe; ack_b = b_oe; trk_a = a_trk;
        wait_clk(4);
        scl = 1'b0; wait_clk(4);
    endtask

    task automatic pulse_done();
        @(negedge clk) conv_done = 1'b1;
        @(negedge clk) conv_done = 1'b0;
        wait_clk(2);
    endtask

    // Full matched conversion/limit command for dut_i with checks on the handshake
    task automatic run_a(input logic [7:0] b, input int exp_ack, input int exp_trk,
                         input int exp_cs);
        logic ka, kb, tk;
        int c0;
        bus_start();
        c0 = cs_cnt;
        send_cmd(b, ka, kb, tk);
        chk("R2 ack during ninth clock", ka, exp_ack);
        chk("R9 track mid-ACK", tk, exp_trk);
        bus_bit(1'b1);
        chk("R9 hold after next rise", a_trk, 0);
        chk("R9 conv_start pulses", cs_cnt - c0, exp_cs);
        bus_stop();
    endtask

    initial begin
        logic ka, kb, tk;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        chk("R1 reset sda_oe", a_oe, 0);
        chk("R1 reset cmd_valid", a_val, 0);
        chk("R1 reset track", a_trk, 0);

        // R1: a matching byte clocked without START
        scl = 1'b0; wait_clk(4);
        for (int i = 7; i >= 0; i--) bus_bit(i[0] ^ 1'b1);
        bus_bit(1'b1);
        chk("R1 no decode without START", a_val, 0);
        scl = 1'b1; wait_clk(8);
        bus_stop();

        run_a(8'b1001_0_00_1, 1, 1, 1);
        chk("R5 channel 00", a_ch, 0);
        chk("R8 read bit 1", a_rd, 1);
        chk("R4 conversion", a_conv, 1);

        run_a(8'b1001_0_01_0, 1, 1, 1);
        chk("R5 channel 01", a_ch, 1);
        chk("R8 read bit 0", a_rd, 0);

        run_a(8'b1001_0_10_1, 1, 1, 1);
        chk("R5 channel 10", a_ch, 2);

        run_a(8'b1001_0_11_0, 1, 1, 1);
        chk("R6 auto set", a_auto, 1);
        chk("R6 auto starts at 0", a_ch, 0);
        chk("R10 mode kept past STOP", a_val, 1);
        pulse_done(); chk("R7 step to 1", a_ch, 1);
        pulse_done(); chk("R7 step to 2", a_ch, 2);
        pulse_done(); chk("R7 wrap after 2", a_ch, 0);
        pulse_done(); chk("R10 stepping after STOP", a_ch, 1);

        run_a(8'b1001_1_01_1, 1, 0, 0);
        chk("R4 limit access", a_conv, 0);
        chk("R6 auto cleared", a_auto, 0);
        chk("R5 limit channel", a_ch, 1);

        run_a(8'b1001_1_11_0, 1, 0, 0);
        chk("R6 code 11 with limit no auto", a_auto, 0);
        pulse_done(); chk("R6 no stepping", a_ch, 3);

        // R3: identifier nobody owns
        bus_start();
        send_cmd(8'b0001_0_10_1, ka, kb, tk);
        chk("R3 no ack on mismatch", ka, 0);
        chk("R3 line released", sda_line, 1);
        bus_bit(1'b1);
        chk("R3 mode cleared", a_val, 0);
        chk("R3 no track", a_trk, 0);
        bus_stop();
        chk("R3 still ignored", a_val, 0);

        // Strapped two-channel unit (id 0101) auto-increment; dut_i must ignore
        bus_start();
        send_cmd(8'b0101_0_11_0, ka, kb, tk);
        chk("R2 strapped id acks", kb, 1);
        chk("R3 fixed unit silent", ka, 0);
        bus_bit(1'b1);
        bus_stop();
        chk("R3 fixed unit idle", a_val, 0);
        chk("R6 strapped auto", b_auto, 1);
        chk("R6 strapped starts 0", b_ch, 0);
        pulse_done(); chk("R7 two-ch step", b_ch, 1);
        pulse_done(); chk("R7 two-ch wrap after 1", b_ch, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule